// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is the execution datapath of a small single-cycle processor, with no decoder of its own. Each clock cycle it fetches one word from a built-in 32-word program ROM at the program counter. It reads two registers named by that word and runs them, or one register and an extended immediate, through an ALU. It can read or write a 32-word data RAM and write one result back into a 32-entry register file. Every steering decision comes from control inputs that an external control unit, or a testbench, supplies for each instruction.

The instruction word follows a fixed field layout:

- The first source register index is in bits 25..21.
- The second source register index is in bits 20..16.
- The alternative destination index is in bits 15..11.
- The 16-bit immediate is in bits 15..0.
- The 26-bit jump target is in bits 25..0.

The built-in program runs as follows:

- Words 0-3 set r1=1 and r2=2, add r1 into r2, and jump back to word 2.
- Words 4-7 load 0x8001 into r3..r6 under each extender mode.
- Words 8-15 exercise subtract, overflow, set-less-than and the logic operations.
- Words 16-19 perform a RAM load, a store, a second load and a read-back.
- Words 20-22 attempt a write to r0 and read registers back.
- Word 23 jumps to 0x02000001.

The store, loads and read-back at words 16-19 address RAM word 5. Words 24-31 hold zero.

Top module: `sc_datapath`

## Requirements
- R1: An asynchronous reset drives the program counter, every register and every RAM word to zero.
- R2: When take_jump is 0, the program counter advances by one on each rising clock edge.
- R3: When take_jump is 1, the next program counter is bits 25..0 of the current instruction, zero-extended to 32 bits.
- R4: The ROM is addressed by the low 5 bits of the program counter. Bits 25..21 of the instruction select the ALU x operand (read port A). Bits 20..16 select read port B.
- R5: A register write happens on a rising edge when rf_we is 1. The write address is bits 20..16 when wr_sel_rd is 0 and bits 15..11 when wr_sel_rd is 1.
- R6: Register 0 always reads as zero, and writes aimed at it are ignored.
- R7: When y_from_imm is 0, the ALU y operand is read port B. When y_from_imm is 1, it is the extender output.
- R8: The extender modes are set by ext_mode. Mode 00 places the immediate in bits 31..16 with zeros below. Modes 01 and 10 sign-extend from bit 15. Mode 11 zero-extends.
- R9: The ALU function is set by alu_mode. Mode 00 passes y. Mode 01 gives 1 when x<y as signed numbers and 0 otherwise. Mode 10 adds, or subtracts x-y when sub_en is 1. Mode 11 applies logic_op: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R10: ovf is the signed overflow of the add or subtract in mode 10, and is 0 in every other mode. is_zero is 1 exactly when alu_out is all zeros.
- R11: The data RAM is addressed by alu_out[4:0]. On a rising edge with mem_we at 1, it stores read port B.
- R12: The register write-back data is alu_out when wb_from_mem is 0, and the RAM word at alu_out[4:0] when wb_from_mem is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| wr_sel_rd | input | 1 | Destination index from bits 15..11 when 1, bits 20..16 when 0 |
| y_from_imm | input | 1 | ALU y operand from extender when 1 |
| wb_from_mem | input | 1 | Write back RAM data when 1, ALU result when 0 |
| rf_we | input | 1 | Register file write enable |
| mem_we | input | 1 | Data RAM write enable |
| sub_en | input | 1 | Subtract instead of add in arithmetic mode |
| logic_op | input | 2 | Logic function select |
| alu_mode | input | 2 | ALU function group select |
| ext_mode | input | 2 | Immediate extension mode |
| take_jump | input | 1 | Load the jump target into the program counter |
| pc_q | output | 32 | Current program counter |
| alu_out | output | 32 | ALU result |
| ovf | output | 1 | Signed overflow of add/subtract |
| is_zero | output | 1 | ALU result is zero |

## Verification
The bench builds the block with its default parameters: 32-bit data and 5-bit ROM, register and RAM indices.

With 5-bit ROM addressing, a jump to 0x02000001 is observable twice. The full target shows on pc_q, while the folded low bits fetch ROM word 1.

With 32-bit data, doubling 0x80010000 produces a true signed overflow. The sign, zero and upper-placement extender modes then give three distinct results from one immediate.

Register effects are made visible by reading registers back through later additions.

// File: rtl/sc_dp_pkg.sv
package sc_dp_pkg;

  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int IDX_W  = 5;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  typedef enum logic [1:0] {ALU_PASS = 2'd0, ALU_SLT = 2'd1, ALU_ARITH = 2'd2, ALU_LOGIC = 2'd3} alu_mode_e;
  typedef enum logic [1:0] {LGC_AND = 2'd0, LGC_OR = 2'd1, LGC_XOR = 2'd2, LGC_NOR = 2'd3} lgc_op_e;
  typedef enum logic [1:0] {EXT_UPPER = 2'd0, EXT_SGN_A = 2'd1, EXT_SGN_B = 2'd2, EXT_ZERO = 2'd3} ext_mode_e;

  typedef struct packed {
    logic [XLEN-1:0] sum;
    logic            ovf;
  } addsub_t;

  // two's complement add or subtract with signed overflow flag
  function automatic addsub_t addsub(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic sub);
    addsub_t         r;
    logic [XLEN-1:0] bb;
    bb    = sub ? ~b : b;
    r.sum = a + bb + XLEN'(sub);
    r.ovf = (a[XLEN-1] == bb[XLEN-1]) && (r.sum[XLEN-1] != a[XLEN-1]);
    return r;
  endfunction

  function automatic logic [XLEN-1:0] logic_fn(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input lgc_op_e op);
    case (op)
      LGC_AND: return a & b;
      LGC_OR:  return a | b;
      LGC_XOR: return a ^ b;
      default: return ~(a | b);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] ext_imm(input logic [IMM_W-1:0] imm, input ext_mode_e m);
    case (m)
      EXT_UPPER: return {imm, {(XLEN-IMM_W){1'b0}}};
      EXT_ZERO:  return {{(XLEN-IMM_W){1'b0}}, imm};
      default:   return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endcase
  endfunction

endpackage

// File: rtl/sc_prog_rom.sv
module sc_prog_rom
  import sc_dp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]   addr,
  output logic [XLEN-1:0] word
);

  localparam logic [5:0] OP_R = 6'h00;
  localparam logic [5:0] OP_I = 6'h08;
  localparam logic [5:0] OP_J = 6'h02;

  function automatic logic [XLEN-1:0] enc_i(input int s, input int t, input logic [IMM_W-1:0] imm);
    return {OP_I, IDX_W'(s), IDX_W'(t), imm};
  endfunction

  function automatic logic [XLEN-1:0] enc_r(input int s, input int t, input int d);
    return {OP_R, IDX_W'(s), IDX_W'(t), IDX_W'(d), 5'd0, 6'h20};
  endfunction

  function automatic logic [XLEN-1:0] enc_j(input logic [TGT_W-1:0] tgt);
    return {OP_J, tgt};
  endfunction

  always_comb begin
    case (int'(addr))
      0:  word = enc_i(0, 1, 16'h0001);
      1:  word = enc_i(0, 2, 16'h0002);
      2:  word = enc_r(2, 1, 2);
      3:  word = enc_j(26'd2);
      4:  word = enc_i(0, 3, 16'h8001);
      5:  word = enc_i(0, 4, 16'h8001);
      6:  word = enc_i(0, 5, 16'h8001);
      7:  word = enc_i(0, 6, 16'h8001);
      8:  word = enc_r(3, 3, 7);
      9:  word = enc_r(3, 3, 8);
      10: word = enc_r(4, 1, 9);
      11: word = enc_r(1, 4, 10);
      12, 13, 14, 15: word = enc_r(4, 5, 11);
      16: word = enc_i(0, 12, 16'h0005);
      17: word = enc_i(0, 2, 16'h0005);
      18: word = enc_i(0, 13, 16'h0005);
      19: word = enc_r(12, 13, 14);
      20: word = enc_i(0, 0, 16'h1234);
      21: word = enc_r(0, 9, 15);
      22: word = enc_r(3, 0, 16);
      23: word = enc_j(26'h2000001);
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
  import sc_dp_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wdata,
  input  logic          we,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];
  logic         wr_fire;

  assign wr_fire = we && (wa != '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[wa] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];

  // register 0 reads zero on both ports whatever was attempted
  assert_r0_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (ra_addr == '0) |-> (ra_data == '0));
  assert_r0_port_b_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rb_addr == '0) |-> (rb_data == '0));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_dp_pkg::*;
(
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  logic            sub_en,
  input  lgc_op_e         lop,
  input  alu_mode_e       mode,
  output logic [XLEN-1:0] res,
  output logic            ovf,
  output logic            zero
);

  addsub_t as_r;
  logic    lt_signed;

  assign as_r      = addsub(x, y, sub_en);
  assign lt_signed = $signed(x) < $signed(y);

  always_comb begin
    ovf = 1'b0;
    case (mode)
      ALU_PASS:  res = y;
      ALU_SLT:   res = {{(XLEN-1){1'b0}}, lt_signed};
      ALU_ARITH: begin
        res = as_r.sum;
        ovf = as_r.ovf;
      end
      default:   res = logic_fn(x, y, lop);
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/sc_data_ram.sv
module sc_data_ram
  import sc_dp_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // a stored word is returned when the same word is read on the next cycle
  assert_store_readback_R11: assert property (@(posedge clk) disable iff (rst)
    we |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_dp_pkg::*;
#(
  parameter int ROM_AW = 5,
  parameter int RF_AW  = IDX_W,
  parameter int RAM_AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_sel_rd,
  input  logic            y_from_imm,
  input  logic            wb_from_mem,
  input  logic            rf_we,
  input  logic            mem_we,
  input  logic            sub_en,
  input  logic [1:0]      logic_op,
  input  logic [1:0]      alu_mode,
  input  logic [1:0]      ext_mode,
  input  logic            take_jump,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] alu_out,
  output logic            ovf,
  output logic            is_zero
);

  localparam int PAD_W = XLEN - TGT_W;

  // named internal events
  logic [XLEN-1:0]  instr;
  logic [XLEN-1:0]  pc_next;
  logic [XLEN-1:0]  jump_tgt;
  logic [RF_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0]  x_opnd, port_b, imm_val, y_opnd;
  logic [XLEN-1:0]  ram_q, wb_data;

  // program counter
  assign jump_tgt = {{PAD_W{1'b0}}, instr[TGT_W-1:0]};
  assign pc_next  = take_jump ? jump_tgt : (pc_q + XLEN'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  sc_prog_rom #(.AW(ROM_AW)) u_rom (
    .addr (pc_q[ROM_AW-1:0]),
    .word (instr)
  );

  // register index routing
  assign rs_idx = instr[RS_LSB +: RF_AW];
  assign rt_idx = instr[RT_LSB +: RF_AW];
  assign rd_idx = instr[RD_LSB +: RF_AW];
  assign wr_idx = wr_sel_rd ? rd_idx : rt_idx;

  sc_regbank #(.W(XLEN), .AW(RF_AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_addr (rs_idx),
    .rb_addr (rt_idx),
    .wa      (wr_idx),
    .wdata   (wb_data),
    .we      (rf_we),
    .ra_data (x_opnd),
    .rb_data (port_b)
  );

  // operand selection
  assign imm_val = ext_imm(instr[IMM_W-1:0], ext_mode_e'(ext_mode));
  assign y_opnd  = y_from_imm ? imm_val : port_b;

  sc_alu u_alu (
    .x      (x_opnd),
    .y      (y_opnd),
    .sub_en (sub_en),
    .lop    (lgc_op_e'(logic_op)),
    .mode   (alu_mode_e'(alu_mode)),
    .res    (alu_out),
    .ovf    (ovf),
    .zero   (is_zero)
  );

  sc_data_ram #(.W(XLEN), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .addr  (alu_out[RAM_AW-1:0]),
    .wdata (port_b),
    .rdata (ram_q)
  );

  assign wb_data = wb_from_mem ? ram_q : alu_out;

  // ---------------- assertions ----------------
  assert_pc_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (pc_q == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !take_jump |=> (pc_q == $past(pc_q) + XLEN'(1)));

  assert_pc_jump_R3: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> (pc_q[XLEN-1:TGT_W] == '0) && (pc_q[TGT_W-1:0] == $past(instr[TGT_W-1:0])));

  assert_opcode_known_R4: assert property (@(posedge clk) disable iff (rst)
    instr[XLEN-1:XLEN-6] inside {6'h00, 6'h02, 6'h08});

  assert_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (y_from_imm && ext_mode == 2'b11) |-> (y_opnd[XLEN-1:IMM_W] == '0));

  assert_slt_boolean_R9: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'b01) |-> (alu_out[XLEN-1:1] == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (alu_mode != 2'b10) |-> !ovf);

endmodule

// File: tb/sc_datapath_tb_top.sv
`timescale 1ns/1ps
module sc_datapath_tb_top;

  localparam logic [1:0] M_PASS = 2'd0, M_SLT = 2'd1, M_ARITH = 2'd2, M_LOGIC = 2'd3;
  localparam logic [1:0] E_UP = 2'd0, E_SGN = 2'd1, E_SGN2 = 2'd2, E_ZX = 2'd3;
  localparam logic [1:0] L_AND = 2'd0, L_OR = 2'd1, L_XOR = 2'd2, L_NOR = 2'd3;

  logic        clk, rst;
  logic        wr_sel_rd, y_from_imm, wb_from_mem, rf_we, mem_we, sub_en, take_jump;
  logic [1:0]  logic_op, alu_mode, ext_mode;
  logic [31:0] pc_q, alu_out;
  logic        ovf, is_zero;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] q_pc[$];
  logic [31:0] q_res[$];
  logic        q_ovf[$];
  string       q_tag[$];
  event        smp_ev;

  sc_datapath dut_i (
    .clk(clk), .rst(rst), .wr_sel_rd(wr_sel_rd), .y_from_imm(y_from_imm),
    .wb_from_mem(wb_from_mem), .rf_we(rf_we), .mem_we(mem_we), .sub_en(sub_en),
    .logic_op(logic_op), .alu_mode(alu_mode), .ext_mode(ext_mode),
    .take_jump(take_jump), .pc_q(pc_q), .alu_out(alu_out), .ovf(ovf), .is_zero(is_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: applies one instruction's controls and queues what must appear
  task automatic step(input logic i_rd, input logic i_imm, input logic i_wb, input logic i_rfwe,
                      input logic i_mwe, input logic i_sub, input logic [1:0] i_lop,
                      input logic [1:0] i_mode, input logic [1:0] i_ext, input logic i_jmp,
                      input logic [31:0] e_pc, input logic [31:0] e_res, input logic e_ovf,
                      input string tag);
    wr_sel_rd = i_rd; y_from_imm = i_imm; wb_from_mem = i_wb; rf_we = i_rfwe;
    mem_we = i_mwe; sub_en = i_sub; logic_op = i_lop; alu_mode = i_mode;
    ext_mode = i_ext; take_jump = i_jmp;
    q_pc.push_back(e_pc); q_res.push_back(e_res); q_ovf.push_back(e_ovf); q_tag.push_back(tag);
    #1;
    -> smp_ev;
    @(negedge clk);
  endtask

  // monitor: pops one expectation per sample point
  initial begin
    forever begin
      logic [31:0] p, r;
      logic        o;
      string       t;
      @(smp_ev);
      p = q_pc.pop_front(); r = q_res.pop_front(); o = q_ovf.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (pc_q !== p || alu_out !== r || ovf !== o || is_zero !== (r == 32'd0)) begin
        n_err++;
        $display("FAIL %s: pc=%h res=%h ovf=%b zero=%b expected pc=%h res=%h ovf=%b zero=%b",
                 t, pc_q, alu_out, ovf, is_zero, p, r, o, (r == 32'd0));
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1;
    wr_sel_rd = 0; y_from_imm = 0; wb_from_mem = 0; rf_we = 0; mem_we = 0;
    sub_en = 0; logic_op = 0; alu_mode = M_PASS; ext_mode = E_UP; take_jump = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pc in reset", pc_q, 32'd0);
    chk("R1 alu in reset", alu_out, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    //    rd imm wb rfwe mwe sub lop    mode     ext   jmp  pc          res          ovf
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd0, 32'd1, 0, "R7 addi r1");
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd1, 32'd2, 0, "R7 addi r2");
    step(1, 0, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd2, 32'd3, 0, "R5 loop add pass1");
    step(0, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 1, 32'd3, 32'd0, 0, "R3 jump word");
    step(1, 0, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd2, 32'd4, 0, "R3 loop add pass2");
    step(0, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 1, 32'd3, 32'd0, 0, "R3 jump word");
    step(1, 0, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd2, 32'd5, 0, "R3 loop add pass3");
    step(0, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd3, 32'd0, 0, "R2 fall through");
    step(0, 1, 0, 1, 0, 0, L_AND, M_PASS,  E_UP,  0, 32'd4, 32'h80010000, 0, "R8 upper mode");
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd5, 32'hFFFF8001, 0, "R8 sign mode 01");
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_ZX,  0, 32'd6, 32'h00008001, 0, "R8 zero mode");
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN2,0, 32'd7, 32'hFFFF8001, 0, "R8 sign mode 10");
    step(1, 0, 0, 1, 0, 1, L_AND, M_ARITH, E_UP,  0, 32'd8, 32'd0, 0, "R10 subtract zero");
    step(1, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_UP,  0, 32'd9, 32'h00020000, 1, "R10 add overflow");
    step(1, 0, 0, 1, 0, 0, L_AND, M_SLT,   E_UP,  0, 32'd10, 32'd1, 0, "R9 slt negative<1");
    step(1, 0, 0, 0, 0, 0, L_AND, M_SLT,   E_UP,  0, 32'd11, 32'd0, 0, "R9 slt 1<negative");
    step(1, 0, 0, 0, 0, 0, L_AND, M_LOGIC, E_UP,  0, 32'd12, 32'h00008001, 0, "R9 and");
    step(1, 0, 0, 0, 0, 0, L_OR,  M_LOGIC, E_UP,  0, 32'd13, 32'hFFFF8001, 0, "R9 or");
    step(1, 0, 0, 0, 0, 0, L_XOR, M_LOGIC, E_UP,  0, 32'd14, 32'hFFFF0000, 0, "R9 xor");
    step(1, 0, 0, 0, 0, 0, L_NOR, M_LOGIC, E_UP,  0, 32'd15, 32'h00007FFE, 0, "R9 nor");
    step(0, 1, 1, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd16, 32'd5, 0, "R12 load cleared word");
    step(0, 1, 0, 0, 1, 0, L_AND, M_ARITH, E_SGN, 0, 32'd17, 32'd5, 0, "R11 store r2");
    step(0, 1, 1, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd18, 32'd5, 0, "R12 load stored word");
    step(1, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd19, 32'd5, 0, "R11 readback r12+r13");
    step(0, 1, 0, 1, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd20, 32'h00001234, 0, "R6 write to r0");
    step(1, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd21, 32'd1, 0, "R6 r0 plus r9");
    step(1, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd22, 32'h80010000, 0, "R5 rd routing kept r3");
    step(0, 0, 0, 0, 0, 0, L_AND, M_PASS,  E_SGN, 1, 32'd23, 32'd0, 0, "R3 wide jump");
    step(0, 1, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'h02000001, 32'd2, 0, "R4 low bits fetch");
    // asynchronous reset in mid-run
    rst = 1'b1;
    #1;
    chk("R1 async pc clear", pc_q, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, L_AND, M_ARITH, E_SGN, 0, 32'd0, 32'd0, 0, "R1 r1 cleared");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog: cycles=%0d expected fewer than %0d", 4000, 4000);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule